// File: doc/BRIEF.md
# Multiplexed Address/Data Port Override

This block turns a general-purpose 8-bit I/O port into the shared low-address and data lanes of an external memory bus. The bus sequencer supplies four things: a bus enable, a flag that marks the address phase, a write strobe and the two outgoing bytes. From these the block produces, for every pin, the override controls that take the pin away from its port registers. These are the output-driver direction, the driven value and the pull-up. The block also returns the byte present on the pins as read data.

While the bus is enabled, the pins drive during the address phase and during writes. They float during reads, when the pull-ups may be used. While the bus is disabled, every override is inactive and the port stays plain GPIO. All outputs are registered, so each one reflects the inputs sampled at the previous rising clock edge. A synchronous active-high reset clears them.

Top module: `membus_pin_mux`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, every output is 0.
- R2: The pull-up, direction and value override enables of every pin each equal `xmem_en` as sampled at the previous edge.
- R3: The direction override value of every pin is 1 when the bus is enabled and either `addr_phase` or `wr_strobe` is 1, and 0 otherwise. A 1 means the pin drives.
- R4: The value override of pin i is (`addr_lo[i]` AND `addr_phase`) OR (`data_out[i]` AND `wr_strobe`) while the bus is enabled.
- R5: The pull-up override value of pin i is `port_bits[i]` AND NOT `pullup_off` when the bus is enabled and neither `addr_phase` nor `wr_strobe` is set, and 0 otherwise.
- R6: Both input-enable override outputs are 0 for every pin at all times.
- R7: `rd_data[i]` equals `pin_in[i]` as sampled at the previous edge, whatever the bus state.
- R8: With `xmem_en` at 0, every override enable and every override value is 0, whatever the other inputs are.
- R9: The sequencer never raises `addr_phase` and `wr_strobe` in the same cycle. This is a constraint on the environment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xmem_en | input | 1 | External memory bus enable |
| addr_phase | input | 1 | Address is being output |
| wr_strobe | input | 1 | Write data is being output |
| addr_lo | input | PINS | Low address byte |
| data_out | input | PINS | Outgoing write data |
| port_bits | input | PINS | Port output register bits |
| pullup_off | input | 1 | Global pull-up disable |
| pin_in | input | PINS | Digital input from the pins |
| pu_ovr_en | output | PINS | Pull-up override enable |
| pu_ovr_val | output | PINS | Pull-up override value |
| dir_ovr_en | output | PINS | Direction override enable |
| dir_ovr_val | output | PINS | Direction override value |
| val_ovr_en | output | PINS | Output value override enable |
| val_ovr_val | output | PINS | Output value override value |
| ie_ovr_en | output | PINS | Input-enable override enable |
| ie_ovr_val | output | PINS | Input-enable override value |
| rd_data | output | PINS | Incoming data byte |

## Verification
The bench builds the block with the default `PINS` of 8, the width of a real port. At that width each bit's address byte, data byte and port bit can be set independently from random stimulus. The run moves through segments with the bus off, held in the address phase, held in write, and reading with the pull-up disable both clear and set, followed by a random mix of phases. This makes every term of the value and pull-up equations observable with both polarities on neighbouring pins.

// File: rtl/mbo_pkg.sv
package mbo_pkg;
  typedef struct packed {
    logic pu_en;
    logic pu_val;
    logic dir_en;
    logic dir_val;
    logic val_en;
    logic val_val;
  } pin_ovr_t;

  localparam pin_ovr_t OVR_IDLE = '0;
endpackage

// File: rtl/mbo_pin_slice.sv
module mbo_pin_slice
  import mbo_pkg::*;
(
  input  logic     bus_en,
  input  logic     phase,
  input  logic     wr,
  input  logic     a_bit,
  input  logic     d_bit,
  input  logic     port_bit,
  input  logic     pud,
  output pin_ovr_t ovr
);
  logic drive;

  always_comb begin
    drive = phase | wr;
    ovr   = OVR_IDLE;
    if (bus_en) begin
      ovr.pu_en   = 1'b1;
      ovr.dir_en  = 1'b1;
      ovr.val_en  = 1'b1;
      ovr.dir_val = drive;
      ovr.val_val = (a_bit & phase) | (d_bit & wr);
      ovr.pu_val  = ~drive & port_bit & ~pud;
    end
  end
endmodule

// File: rtl/mbo_ovr_reg.sv
module mbo_ovr_reg
  import mbo_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  pin_ovr_t [PINS-1:0]   nxt,
  output pin_ovr_t [PINS-1:0]   cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= '0;
    else     cur <= nxt;
  end
endmodule

// File: rtl/mbo_rd_capture.sv
module mbo_rd_capture #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pins,
  output logic [PINS-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) data <= '0;
    else     data <= pins;
  end
endmodule

// File: rtl/membus_pin_mux.sv
module membus_pin_mux
  import mbo_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            xmem_en,
  input  logic            addr_phase,
  input  logic            wr_strobe,
  input  logic [PINS-1:0] addr_lo,
  input  logic [PINS-1:0] data_out,
  input  logic [PINS-1:0] port_bits,
  input  logic            pullup_off,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pu_ovr_en,
  output logic [PINS-1:0] pu_ovr_val,
  output logic [PINS-1:0] dir_ovr_en,
  output logic [PINS-1:0] dir_ovr_val,
  output logic [PINS-1:0] val_ovr_en,
  output logic [PINS-1:0] val_ovr_val,
  output logic [PINS-1:0] ie_ovr_en,
  output logic [PINS-1:0] ie_ovr_val,
  output logic [PINS-1:0] rd_data
);
  pin_ovr_t [PINS-1:0] ovr_nxt;
  pin_ovr_t [PINS-1:0] ovr_q;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    mbo_pin_slice u_slice (
      .bus_en   (xmem_en),
      .phase    (addr_phase),
      .wr       (wr_strobe),
      .a_bit    (addr_lo[i]),
      .d_bit    (data_out[i]),
      .port_bit (port_bits[i]),
      .pud      (pullup_off),
      .ovr      (ovr_nxt[i])
    );

    assign pu_ovr_en[i]   = ovr_q[i].pu_en;
    assign pu_ovr_val[i]  = ovr_q[i].pu_val;
    assign dir_ovr_en[i]  = ovr_q[i].dir_en;
    assign dir_ovr_val[i] = ovr_q[i].dir_val;
    assign val_ovr_en[i]  = ovr_q[i].val_en;
    assign val_ovr_val[i] = ovr_q[i].val_val;
  end

  mbo_ovr_reg #(.PINS(PINS)) u_ovr_reg (
    .clk (clk),
    .rst (rst),
    .nxt (ovr_nxt),
    .cur (ovr_q)
  );

  mbo_rd_capture #(.PINS(PINS)) u_rd (
    .clk  (clk),
    .rst  (rst),
    .pins (pin_in),
    .data (rd_data)
  );

  // The bus never overrides the input enable of these pins.
  assign ie_ovr_en  = '0;
  assign ie_ovr_val = '0;
endmodule

// File: rtl/mbo_checker.sv
module mbo_checker #(
  parameter int PINS = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            xmem_en,
  input logic            addr_phase,
  input logic            wr_strobe,
  input logic [PINS-1:0] addr_lo,
  input logic [PINS-1:0] data_out,
  input logic [PINS-1:0] port_bits,
  input logic            pullup_off,
  input logic [PINS-1:0] pin_in,
  input logic [PINS-1:0] pu_ovr_en,
  input logic [PINS-1:0] pu_ovr_val,
  input logic [PINS-1:0] dir_ovr_en,
  input logic [PINS-1:0] dir_ovr_val,
  input logic [PINS-1:0] val_ovr_en,
  input logic [PINS-1:0] val_ovr_val,
  input logic [PINS-1:0] rd_data
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pu_ovr_en == '0 && dir_ovr_en == '0 && val_ovr_en == '0 &&
                    pu_ovr_val == '0 && dir_ovr_val == '0 && val_ovr_val == '0 &&
                    rd_data == '0));

  assert_enables_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pu_ovr_en == {PINS{$past(xmem_en)}} &&
                     dir_ovr_en == {PINS{$past(xmem_en)}} &&
                     val_ovr_en == {PINS{$past(xmem_en)}}));

  assert_direction_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> dir_ovr_val ==
      {PINS{$past(xmem_en && (addr_phase || wr_strobe))}});

  assert_value_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> val_ovr_val ==
      ($past(xmem_en) ? (($past(addr_lo) & {PINS{$past(addr_phase)}}) |
                         ($past(data_out) & {PINS{$past(wr_strobe)}})) : '0));

  assert_pullup_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pu_ovr_val ==
      ($past(xmem_en && !addr_phase && !wr_strobe && !pullup_off) ?
        $past(port_bits) : '0));

  assert_read_capture_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rd_data == $past(pin_in));

  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(xmem_en)) |->
      (pu_ovr_val == '0 && dir_ovr_val == '0 && val_ovr_val == '0));

  assert_phase_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(addr_phase && wr_strobe));
endmodule

bind membus_pin_mux mbo_checker #(.PINS(PINS)) u_mbo_checker (
  .clk         (clk),
  .rst         (rst),
  .xmem_en     (xmem_en),
  .addr_phase  (addr_phase),
  .wr_strobe   (wr_strobe),
  .addr_lo     (addr_lo),
  .data_out    (data_out),
  .port_bits   (port_bits),
  .pullup_off  (pullup_off),
  .pin_in      (pin_in),
  .pu_ovr_en   (pu_ovr_en),
  .pu_ovr_val  (pu_ovr_val),
  .dir_ovr_en  (dir_ovr_en),
  .dir_ovr_val (dir_ovr_val),
  .val_ovr_en  (val_ovr_en),
  .val_ovr_val (val_ovr_val),
  .rd_data     (rd_data)
);

// File: tb/test_membus_pin_mux.sv
module test_membus_pin_mux;
  localparam int PINS   = 8;
  localparam int CYCLES = 360;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            xmem_en = 1'b0, addr_phase = 1'b0, wr_strobe = 1'b0, pullup_off = 1'b0;
  logic [PINS-1:0] addr_lo = '0, data_out = '0, port_bits = '0, pin_in = '0;
  logic [PINS-1:0] pu_ovr_en, pu_ovr_val, dir_ovr_en, dir_ovr_val;
  logic [PINS-1:0] val_ovr_en, val_ovr_val, ie_ovr_en, ie_ovr_val, rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // values applied before the most recent rising edge
  logic            p_rst, p_x, p_ph, p_wr, p_pud;
  logic [PINS-1:0] p_a, p_d, p_port, p_pin;

  always #5 clk = ~clk;

  membus_pin_mux #(.PINS(PINS)) i_membus_pin_mux (
    .clk(clk), .rst(rst), .xmem_en(xmem_en), .addr_phase(addr_phase),
    .wr_strobe(wr_strobe), .addr_lo(addr_lo), .data_out(data_out),
    .port_bits(port_bits), .pullup_off(pullup_off), .pin_in(pin_in),
    .pu_ovr_en(pu_ovr_en), .pu_ovr_val(pu_ovr_val), .dir_ovr_en(dir_ovr_en),
    .dir_ovr_val(dir_ovr_val), .val_ovr_en(val_ovr_en), .val_ovr_val(val_ovr_val),
    .ie_ovr_en(ie_ovr_en), .ie_ovr_val(ie_ovr_val), .rd_data(rd_data)
  );

  task automatic check(string tag, string what, logic [PINS-1:0] act, logic [PINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [PINS-1:0] e_en, e_dir, e_val, e_pu;
    string vtag;
    e_en = '0; e_dir = '0; e_val = '0; e_pu = '0;
    if (p_rst) begin
      check("R1", "pu_en", pu_ovr_en, '0);   check("R1", "pu_val", pu_ovr_val, '0);
      check("R1", "dir_en", dir_ovr_en, '0); check("R1", "dir_val", dir_ovr_val, '0);
      check("R1", "val_en", val_ovr_en, '0); check("R1", "val_val", val_ovr_val, '0);
      check("R1", "rd_data", rd_data, '0);
    end else begin
      for (int i = 0; i < PINS; i++) begin
        if (p_x) begin
          e_en[i]  = 1'b1;
          e_dir[i] = p_ph || p_wr;
          e_val[i] = (p_a[i] && p_ph) || (p_d[i] && p_wr);
          e_pu[i]  = !p_ph && !p_wr && p_port[i] && !p_pud;
        end
      end
      check("R2", "pu_en", pu_ovr_en, e_en);
      check("R2", "dir_en", dir_ovr_en, e_en);
      check("R2", "val_en", val_ovr_en, e_en);
      vtag = p_x ? "R3" : "R8";
      check(vtag, "dir_val", dir_ovr_val, e_dir);
      vtag = p_x ? "R4" : "R8";
      check(vtag, "val_val", val_ovr_val, e_val);
      vtag = p_x ? "R5" : "R8";
      check(vtag, "pu_val", pu_ovr_val, e_pu);
      check("R7", "rd_data", rd_data, p_pin);
    end
    check("R6", "ie_en", ie_ovr_en, '0);
    check("R6", "ie_val", ie_ovr_val, '0);
  endtask

  // Segment by cycle: 0 off, 1 address, 2 write, 3 read, 4 read with pud, 5 mix.
  task automatic drive(int n);
    int seg;
    int r;
    seg = (n - 4) / 50;
    rst        = (n < 4) || (n == 300);
    addr_lo    = PINS'($urandom);
    data_out   = PINS'($urandom);
    port_bits  = PINS'($urandom);
    pin_in     = PINS'($urandom);
    pullup_off = 1'b0;
    xmem_en    = 1'b1;
    addr_phase = 1'b0;
    wr_strobe  = 1'b0;
    r = int'($urandom % 3);
    case (seg)
      0: begin xmem_en = 1'b0; addr_phase = (r == 1); wr_strobe = (r == 2);
               pullup_off = $urandom % 2; end
      1: addr_phase = 1'b1;
      2: wr_strobe  = 1'b1;
      3: ;
      4: pullup_off = 1'b1;
      default: begin xmem_en = ($urandom % 4) != 0; addr_phase = (r == 1);
                     wr_strobe = (r == 2); pullup_off = $urandom % 2; end
    endcase
  endtask

  initial begin
    for (int n = 0; n < CYCLES; n++) begin
      drive(n);
      p_rst = rst; p_x = xmem_en; p_ph = addr_phase; p_wr = wr_strobe;
      p_pud = pullup_off; p_a = addr_lo; p_d = data_out; p_port = port_bits;
      p_pin = pin_in;
      @(posedge clk);
      @(negedge clk);
      compare();
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule